// File: doc/BRIEF.md
# Exception Escalation Controller

This block sits beside the exception-delivery sequencer of a processor core. It records which kind of exception the core is delivering at the moment. When a new exception arrives before that delivery finishes, the block decides what to do with it. It can pass the new exception on unchanged, replace it with a double fault (vector 8, error code 0), or stop the core in a shutdown state. The decision depends on two things: the class of the delivery in progress and the class of the new exception. The upstream logic supplies each raised exception as a one-cycle strobe that carries a vector, a 2-bit class tag and an error code. It reports the end of a delivery with a separate one-cycle strobe.

The tracking machine has five states. **IDLE** means no tracked delivery. **SEG** means a segment-type fault is being delivered. **PAGE** means a page fault is being delivered. **DBL** means a double fault is being delivered. **SHUT** means shutdown. The transitions are:
- IDLE goes to SEG or PAGE when a segment-type or page-class exception is raised.
- SEG goes to PAGE on a page raise, and to DBL on a segment raise.
- PAGE goes to DBL on any segment or page raise.
- DBL goes to SHUT on any segment or page raise.
- SEG, PAGE and DBL return to IDLE on the completion strobe.
- SHUT returns to IDLE on NMI, or goes to IDLE through reset.

Benign raises never move the machine. Each raise has one of five outcomes: nothing, pass-through, double fault, shutdown entry or NMI request. The block registers the outcome, so the delivery outputs appear one clock after the strobe. While the core is halted, the halt output keeps instruction issue stopped.

Top module: `exc_escalate_ctrl`

## Requirements
- R1: Class tag encoding is 0 = benign, 1 = segment-type, 2 = page, 3 = treated as benign. In IDLE, a raised exception of any class is delivered unchanged on the clock after the strobe: `dlv_vld` is high for one cycle with the raised vector and error code.
- R2: A page-class raise during a segment-type delivery is delivered as the page fault itself, with its own vector and error code, and no double fault.
- R3: A segment-type raise during a segment-type or page delivery produces a double fault: vector 8, error code 0.
- R4: A page-class raise during a page delivery produces a double fault: vector 8, error code 0.
- R5: A segment-type or page-class raise during a double-fault delivery enters shutdown. `halted` goes high on the clock after the strobe, and no delivery is produced.
- R6: Benign raises (class 0 or 3) never escalate. In any state other than shutdown they are delivered unchanged, and the tracked class stays the same.
- R7: The completion strobe returns tracking to IDLE. If a raise and a completion arrive in the same cycle, the raise takes effect and the completion is ignored.
- R8: In shutdown, raises and completion strobes are ignored. No delivery is produced and `halted` stays high.
- R9: NMI in shutdown clears `halted`, returns tracking to IDLE and delivers vector 2 with error code 0. NMI outside shutdown has no effect.
- R10: While reset is asserted, `dlv_vld` and `halted` are low and tracking is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rz_vld | input | 1 | Exception-raised strobe |
| rz_vec | input | VEC_W | Vector of the raised exception |
| rz_cls | input | 2 | Class tag of the raised exception |
| rz_err | input | ERR_W | Error code of the raised exception |
| cmpl_vld | input | 1 | Delivery-complete strobe |
| nmi_req | input | 1 | Non-maskable interrupt request |
| dlv_vld | output | 1 | One-cycle pulse: an exception must be delivered |
| dlv_vec | output | VEC_W | Vector to deliver |
| dlv_err | output | ERR_W | Error code to push |
| halted | output | 1 | Shutdown: instruction issue stopped |

## Verification
The bench walks every pairing of in-flight class and new class. This includes the asymmetric case, where a page fault on a segment delivery passes through. A design that treated that case symmetrically would emit vector 8 where the page vector is expected. It also drives a raise and a completion in the same cycle. A design that let the completion win would pass the second fault through instead of escalating it. Inside shutdown, the bench sends raises, completions and NMI. Any delivery while halted shows up as an unexpected item in the scoreboard, and a missing vector-2 request shows up as a leftover one. An NMI outside shutdown must produce nothing. Reset is also applied while the core is halted.

// File: rtl/esc_pkg.sv
package esc_pkg;

    typedef enum logic [1:0] {
        CLS_BENIGN = 2'd0,
        CLS_SEG    = 2'd1,
        CLS_PAGE   = 2'd2,
        CLS_RSVD   = 2'd3
    } exc_cls_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_SEG  = 3'd1,
        ST_PAGE = 3'd2,
        ST_DBL  = 3'd3,
        ST_SHUT = 3'd4
    } esc_state_t;

    typedef enum logic [2:0] {
        ACT_NONE = 3'd0,
        ACT_PASS = 3'd1,
        ACT_DBL  = 3'd2,
        ACT_SHUT = 3'd3,
        ACT_NMI  = 3'd4
    } esc_act_t;

endpackage

// File: rtl/esc_decide.sv
module esc_decide
    import esc_pkg::*;
(
    input  esc_state_t st,
    input  logic       rz_vld,
    input  logic [1:0] rz_cls,
    input  logic       cmpl_vld,
    input  logic       nmi_req,
    output esc_act_t   act,
    output esc_state_t st_nxt
);

    exc_cls_t cls;
    logic     tracked;

    always_comb begin
        cls     = exc_cls_t'(rz_cls);
        tracked = (cls == CLS_SEG) || (cls == CLS_PAGE);
    end

    always_comb begin
        act    = ACT_NONE;
        st_nxt = st;
        unique case (st)
            ST_SHUT: begin
                if (nmi_req) begin
                    act    = ACT_NMI;
                    st_nxt = ST_IDLE;
                end
            end
            ST_IDLE, ST_SEG, ST_PAGE, ST_DBL: begin
                if (rz_vld) begin
                    if (!tracked) begin
                        act = ACT_PASS;
                    end else begin
                        unique case (st)
                            ST_IDLE: begin
                                act    = ACT_PASS;
                                st_nxt = (cls == CLS_SEG) ? ST_SEG : ST_PAGE;
                            end
                            ST_SEG: begin
                                if (cls == CLS_PAGE) begin
                                    act    = ACT_PASS;
                                    st_nxt = ST_PAGE;
                                end else begin
                                    act    = ACT_DBL;
                                    st_nxt = ST_DBL;
                                end
                            end
                            ST_PAGE: begin
                                act    = ACT_DBL;
                                st_nxt = ST_DBL;
                            end
                            default: begin
                                act    = ACT_SHUT;
                                st_nxt = ST_SHUT;
                            end
                        endcase
                    end
                end else if (cmpl_vld) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: begin
                st_nxt = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/esc_fsm.sv
module esc_fsm
    import esc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  esc_state_t st_nxt,
    output esc_state_t st_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

endmodule

// File: rtl/esc_out.sv
module esc_out
    import esc_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int ERR_W   = 16,
    parameter int DF_VEC  = 8,
    parameter int NMI_VEC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  esc_act_t         act,
    input  logic [VEC_W-1:0] rz_vec,
    input  logic [ERR_W-1:0] rz_err,
    output logic             dlv_vld,
    output logic [VEC_W-1:0] dlv_vec,
    output logic [ERR_W-1:0] dlv_err
);

    localparam logic [VEC_W-1:0] DF_V  = VEC_W'(DF_VEC);
    localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dlv_vld <= 1'b0;
            dlv_vec <= '0;
            dlv_err <= '0;
        end else begin
            unique case (act)
                ACT_PASS: begin
                    dlv_vld <= 1'b1;
                    dlv_vec <= rz_vec;
                    dlv_err <= rz_err;
                end
                ACT_DBL: begin
                    dlv_vld <= 1'b1;
                    dlv_vec <= DF_V;
                    dlv_err <= '0;
                end
                ACT_NMI: begin
                    dlv_vld <= 1'b1;
                    dlv_vec <= NMI_V;
                    dlv_err <= '0;
                end
                default: begin
                    dlv_vld <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/exc_escalate_ctrl.sv
module exc_escalate_ctrl
    import esc_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int ERR_W   = 16,
    parameter int DF_VEC  = 8,
    parameter int NMI_VEC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rz_vld,
    input  logic [VEC_W-1:0] rz_vec,
    input  logic [1:0]       rz_cls,
    input  logic [ERR_W-1:0] rz_err,
    input  logic             cmpl_vld,
    input  logic             nmi_req,
    output logic             dlv_vld,
    output logic [VEC_W-1:0] dlv_vec,
    output logic [ERR_W-1:0] dlv_err,
    output logic             halted
);

    esc_state_t st_q;
    esc_state_t st_nxt;
    esc_act_t   act;

    esc_decide u_decide (
        .st       (st_q),
        .rz_vld   (rz_vld),
        .rz_cls   (rz_cls),
        .cmpl_vld (cmpl_vld),
        .nmi_req  (nmi_req),
        .act      (act),
        .st_nxt   (st_nxt)
    );

    esc_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .st_nxt (st_nxt),
        .st_q   (st_q)
    );

    esc_out #(
        .VEC_W   (VEC_W),
        .ERR_W   (ERR_W),
        .DF_VEC  (DF_VEC),
        .NMI_VEC (NMI_VEC)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .rz_vec  (rz_vec),
        .rz_err  (rz_err),
        .dlv_vld (dlv_vld),
        .dlv_vec (dlv_vec),
        .dlv_err (dlv_err)
    );

    assign halted = (st_q == ST_SHUT);

endmodule

// File: rtl/esc_chk.sv
module esc_chk
    import esc_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int ERR_W   = 16,
    parameter int DF_VEC  = 8,
    parameter int NMI_VEC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rz_vld,
    input logic [VEC_W-1:0] rz_vec,
    input logic [1:0]       rz_cls,
    input logic [ERR_W-1:0] rz_err,
    input logic             nmi_req,
    input logic             dlv_vld,
    input logic [VEC_W-1:0] dlv_vec,
    input logic [ERR_W-1:0] dlv_err,
    input logic             halted,
    input esc_state_t       st
);

    // R2: page fault on top of a segment delivery passes through unchanged
    a_r2_page_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEG && rz_vld && rz_cls == 2'd2)
        |=> (dlv_vld && dlv_vec == $past(rz_vec) && dlv_err == $past(rz_err)));

    // R3: segment fault during a segment delivery becomes a double fault
    a_r3_seg_escalates: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SEG && rz_vld && rz_cls == 2'd1)
        |=> (dlv_vld && dlv_vec == VEC_W'(DF_VEC) && dlv_err == '0));

    // R4: page fault during a page delivery becomes a double fault
    a_r4_page_escalates: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAGE && rz_vld && rz_cls == 2'd2)
        |=> (dlv_vld && dlv_vec == VEC_W'(DF_VEC) && dlv_err == '0));

    // R5: tracked fault during a double-fault delivery halts the core
    a_r5_enter_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DBL && rz_vld && (rz_cls == 2'd1 || rz_cls == 2'd2))
        |=> (halted && !dlv_vld));

    // R8: shutdown is held and silent until NMI
    a_r8_shutdown_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !nmi_req) |=> (halted && !dlv_vld));

    // R9: NMI leaves shutdown with a vector-2 request
    a_r9_nmi_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && nmi_req)
        |=> (!halted && dlv_vld && dlv_vec == VEC_W'(NMI_VEC) && dlv_err == '0));

endmodule

bind exc_escalate_ctrl esc_chk #(
    .VEC_W   (VEC_W),
    .ERR_W   (ERR_W),
    .DF_VEC  (DF_VEC),
    .NMI_VEC (NMI_VEC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rz_vld  (rz_vld),
    .rz_vec  (rz_vec),
    .rz_cls  (rz_cls),
    .rz_err  (rz_err),
    .nmi_req (nmi_req),
    .dlv_vld (dlv_vld),
    .dlv_vec (dlv_vec),
    .dlv_err (dlv_err),
    .halted  (halted),
    .st      (st_q)
);

// File: tb/sim_exc_escalate_ctrl.sv
`timescale 1ns/1ps
module sim_exc_escalate_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rz_vld = 1'b0;
    logic [7:0]  rz_vec = '0;
    logic [1:0]  rz_cls = '0;
    logic [15:0] rz_err = '0;
    logic        cmpl_vld = 1'b0;
    logic        nmi_req = 1'b0;
    logic        dlv_vld;
    logic [7:0]  dlv_vec;
    logic [15:0] dlv_err;
    logic        halted;

    typedef struct {
        logic [7:0]  v;
        logic [15:0] e;
        string       tag;
    } exp_t;

    exp_t  sbq[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    string ctx = "R10";

    always #2 clk = ~clk;

    exc_escalate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rz_vld(rz_vld), .rz_vec(rz_vec),
        .rz_cls(rz_cls), .rz_err(rz_err), .cmpl_vld(cmpl_vld),
        .nmi_req(nmi_req), .dlv_vld(dlv_vld), .dlv_vec(dlv_vec),
        .dlv_err(dlv_err), .halted(halted)
    );

    // monitor: pop and compare each delivery
    always @(negedge clk) begin
        exp_t x;
        if (rst_n && dlv_vld) begin
            n_cmp++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL %s: unexpected delivery vec=%0h err=%0h, expected none",
                         ctx, dlv_vec, dlv_err);
            end else begin
                x = sbq.pop_front();
                if (dlv_vec !== x.v || dlv_err !== x.e) begin
                    n_bad++;
                    $display("FAIL %s: vec=%0h err=%0h, expected vec=%0h err=%0h",
                             x.tag, dlv_vec, dlv_err, x.v, x.e);
                end
            end
        end
    end

    task automatic expect_dlv(input logic [7:0] v, input logic [15:0] e, input string tag);
        exp_t x;
        x.v = v; x.e = e; x.tag = tag;
        sbq.push_back(x);
    endtask

    // drive one raise strobe; optionally queue the expected delivery
    task automatic fire(input logic [7:0] v, input logic [1:0] c, input logic [15:0] e,
                        input bit with_cmpl, input bit expo,
                        input logic [7:0] ev, input logic [15:0] ee, input string tag);
        ctx = tag;
        if (expo) expect_dlv(ev, ee, tag);
        rz_vld = 1'b1; rz_vec = v; rz_cls = c; rz_err = e; cmpl_vld = with_cmpl;
        @(negedge clk);
        rz_vld = 1'b0; cmpl_vld = 1'b0;
    endtask

    task automatic complete(input string tag);
        ctx = tag;
        cmpl_vld = 1'b1;
        @(negedge clk);
        cmpl_vld = 1'b0;
    endtask

    task automatic pulse_nmi(input bit expo, input string tag);
        ctx = tag;
        if (expo) expect_dlv(8'h02, 16'h0000, tag);
        nmi_req = 1'b1;
        @(negedge clk);
        nmi_req = 1'b0;
    endtask

    task automatic chk_halt(input logic exp, input string tag);
        n_cmp++;
        if (halted !== exp) begin
            n_bad++;
            $display("FAIL %s: halted=%0b, expected %0b", tag, halted, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (2) @(negedge clk);
        n_cmp++;
        if (dlv_vld !== 1'b0) begin
            n_bad++;
            $display("FAIL R10: dlv_vld=%0b, expected 0", dlv_vld);
        end
        chk_halt(1'b0, "R10");
        rst_n = 1'b1;
        @(negedge clk);

        // R1: benign and segment raises in IDLE pass through
        fire(8'h00, 2'd0, 16'h0000, 0, 1, 8'h00, 16'h0000, "R1 benign idle");
        fire(8'h0D, 2'd1, 16'h1234, 0, 1, 8'h0D, 16'h1234, "R1 seg idle");
        // R2: page on segment delivery passes as page fault
        fire(8'h0E, 2'd2, 16'h0006, 0, 1, 8'h0E, 16'h0006, "R2 page on seg");
        // R3: segment on page delivery escalates
        fire(8'h0B, 2'd1, 16'h0055, 0, 1, 8'h08, 16'h0000, "R3 seg on page");
        // R6: benign during double fault delivery passes, no shutdown
        fire(8'h06, 2'd0, 16'h0000, 0, 1, 8'h06, 16'h0000, "R6 benign on dbl");
        chk_halt(1'b0, "R6");
        // R5: page during double fault -> shutdown
        fire(8'h0E, 2'd2, 16'h0002, 0, 0, 8'h00, 16'h0000, "R5 page on dbl");
        chk_halt(1'b1, "R5");
        // R8: raises and completion ignored in shutdown
        fire(8'h0D, 2'd1, 16'h0011, 0, 0, 8'h00, 16'h0000, "R8 seg in shut");
        fire(8'h03, 2'd0, 16'h0000, 0, 0, 8'h00, 16'h0000, "R8 benign in shut");
        complete("R8 cmpl in shut");
        chk_halt(1'b1, "R8");
        // R9: NMI leaves shutdown with vector 2
        pulse_nmi(1, "R9 nmi exit");
        chk_halt(1'b0, "R9");

        // R3: segment on segment
        fire(8'h0C, 2'd1, 16'h0010, 0, 1, 8'h0C, 16'h0010, "R1 seg after nmi");
        fire(8'h0A, 2'd1, 16'h0020, 0, 1, 8'h08, 16'h0000, "R3 seg on seg");
        complete("R7 cmpl");
        // R4: page on page
        fire(8'h0E, 2'd2, 16'h0002, 0, 1, 8'h0E, 16'h0002, "R1 page idle");
        fire(8'h0E, 2'd2, 16'h0004, 0, 1, 8'h08, 16'h0000, "R4 page on page");
        complete("R7 cmpl");
        // R6: class 3 counts as benign; does not change tracking
        fire(8'h10, 2'd3, 16'h0000, 0, 1, 8'h10, 16'h0000, "R6 class3 idle");
        fire(8'h0E, 2'd2, 16'h0008, 0, 1, 8'h0E, 16'h0008, "R6 page after benign");
        fire(8'h05, 2'd0, 16'h0000, 0, 1, 8'h05, 16'h0000, "R6 benign on page");
        fire(8'h0E, 2'd2, 16'h000C, 0, 1, 8'h08, 16'h0000, "R6 page still tracked");
        complete("R7 cmpl");

        // R7: raise wins over same-cycle completion
        fire(8'h0D, 2'd1, 16'h0001, 0, 1, 8'h0D, 16'h0001, "R7 seg idle");
        fire(8'h0D, 2'd1, 16'h0002, 1, 1, 8'h08, 16'h0000, "R7 raise beats cmpl");
        complete("R7 cmpl after dbl");
        fire(8'h0D, 2'd1, 16'h0003, 0, 1, 8'h0D, 16'h0003, "R7 tracking cleared");
        complete("R7 cmpl");

        // R9: NMI outside shutdown does nothing
        pulse_nmi(0, "R9 nmi outside shut");
        @(negedge clk);
        chk_halt(1'b0, "R9 nmi outside shut");
        fire(8'h0B, 2'd1, 16'h0007, 0, 1, 8'h0B, 16'h0007, "R9 idle kept");

        // R5 via segment route, then R10 reset exits shutdown
        fire(8'h0B, 2'd1, 16'h0009, 0, 1, 8'h08, 16'h0000, "R3 seg on seg 2");
        fire(8'h0D, 2'd1, 16'h0000, 0, 0, 8'h00, 16'h0000, "R5 seg on dbl");
        chk_halt(1'b1, "R5 seg on dbl");
        ctx = "R10 reset in shut";
        rst_n = 1'b0;
        @(negedge clk);
        chk_halt(1'b0, "R10 reset in shut");
        rst_n = 1'b1;
        @(negedge clk);
        fire(8'h0E, 2'd2, 16'h0001, 0, 1, 8'h0E, 16'h0001, "R10 idle after reset");

        repeat (3) @(negedge clk);
        n_cmp++;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL R1-R9 scoreboard: %0d deliveries missing, expected 0", sbq.size());
        end
        summary();
        $finish;
    end

endmodule